// File: doc/BRIEF.md
# Interrupt-Triggered Micro-DMA Controller

This block is a four-channel transfer engine that takes the place of short interrupt service routines. Each channel is programmed through a small register port with a source address, a destination address, a transfer count, a unit size and an address-stepping mode. A rising edge on the interrupt line assigned to a channel does not run software. Instead, the engine asks the processor to stall, moves one unit from source to destination over a single-cycle memory master port, steps the addresses, and decrements the count. When the count reaches zero, the channel switches itself off and pulses a completion interrupt.

The processor is represented by a stall request output and a stall acknowledge input. The engine issues no memory cycle until the acknowledge is seen. The engine is built around one state machine with five states:
- S_IDLE waits for an eligible channel.
- S_HOLD raises the stall request and waits for the acknowledge.
- S_READ fetches the unit from the source address.
- S_WRITE stores the unit at the destination address.
- S_STEP updates the channel's registers and drops the stall.

The transitions are:
- grant: S_IDLE to S_HOLD.
- acknowledge: S_HOLD to S_READ.
- fetch done: S_READ to S_WRITE.
- store done: S_WRITE to S_STEP.
- release: S_STEP to S_IDLE.

Top module: `udma_ctrl`

## Requirements
- R1: Registers are addressed as reg_addr = {channel[1:0], sel[1:0]}. Sel 0 is the source address, sel 1 the destination address, sel 2 the count (zero-extended on read), and sel 3 the control word. The control word holds enable in bit 0, size in bits 2:1 and mode in bits 4:3, and its other bits read as zero. Every register reads back on reg_rdata in the same cycle.
- R2: Size 0 moves one byte, size 1 a 16-bit word and size 2 a 32-bit longword; size 3 behaves as a longword. Addresses are aligned to the unit. Byte lanes are little-endian, so a unit at address A sits in lanes starting at A[1:0], and mem_be enables only those lanes. Destination bytes outside the unit stay unchanged.
- R3: After each unit, the addresses step by the unit size according to the mode. Mode 0 increments the destination with the source fixed. Mode 1 decrements the destination with the source fixed. Mode 2 increments the source with the destination fixed. Mode 3 keeps both fixed.
- R4: Each service moves exactly one unit and lowers the count by one. When the count goes from 1 to 0, the enable bit clears and done_irq[channel] is high for exactly one cycle. At most one done_irq bit is high at a time.
- R5: A trigger is a rising edge of irq_in[c]. A trigger is latched as one pending request even while the channel is disabled, busy or has a zero count. Further triggers before that request is taken are dropped. A pending request is served once the channel is enabled with a nonzero count.
- R6: When several channels are eligible at once, channel 0 is served first and channel 3 last.
- R7: stall_req rises before any memory cycle. No memory cycle is issued until stall_ack is high. stall_req stays high through the read and the write and falls in the cycle after the write.
- R8: After reset, all channel registers read zero and stall_req, mem_req and done_irq are low.
- R9: A service is one read cycle (mem_req=1, mem_we=0) immediately followed by one write cycle (mem_req=1, mem_we=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 4 | Trigger interrupt per channel, rising edge |
| done_irq | output | 4 | One-cycle completion pulse per channel |
| stall_req | output | 1 | Request to suspend the processor |
| stall_ack | input | 1 | Processor is suspended |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel and register select |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data |
| mem_req | output | 1 | Memory cycle valid |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 24 | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle |

## Verification
The copy function is swept over every combination of unit size and stepping mode. Each combination runs three units on a rotating channel against a memory image whose bytes are a known arithmetic function of their address. This separates lane-placement errors from stepping-direction errors and from wrong final addresses, and a neighbourhood comparison catches stray byte enables. Simultaneous triggers on all channels show whether the priority order holds. Repeated triggers on a disabled channel and on a busy channel show whether exactly one request is kept. A withheld acknowledge shows whether the engine touches memory before the processor is stalled.

// File: rtl/udma_pkg.sv
package udma_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD,
        S_READ,
        S_WRITE,
        S_STEP
    } udma_state_e;

    // bytes per unit: byte, word, longword; code 3 behaves as longword
    function automatic logic [2:0] unit_bytes(input logic [1:0] size);
        case (size)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/udma_prio.sv
module udma_prio #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    always_comb begin
        gnt_vld = |req;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt_idx = IW'(i);
        end
    end
endmodule

// File: rtl/udma_lanes.sv
module udma_lanes
    import udma_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        rd_off,
    input  logic [1:0]        wr_off,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] hold,
    output logic [DATA_W-1:0] rd_val,
    output logic [LANES-1:0]  rd_be,
    output logic [LANES-1:0]  wr_be,
    output logic [DATA_W-1:0] wr_data
);
    logic [2:0]        nb;
    logic [1:0]        ra, wa;
    logic [LANES-1:0]  bmask;
    logic [DATA_W-1:0] vmask;

    always_comb begin
        nb    = unit_bytes(size);
        ra    = rd_off & ~(nb[1:0] - 2'd1);
        wa    = wr_off & ~(nb[1:0] - 2'd1);
        bmask = (nb == 3'd1) ? 4'b0001 : (nb == 3'd2) ? 4'b0011 : 4'b1111;
        vmask = (nb == 3'd1) ? 32'h0000_00FF :
                (nb == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        rd_val  = (rdata >> {ra, 3'b000}) & vmask;
        rd_be   = bmask << ra;
        wr_be   = bmask << wa;
        wr_data = (hold & vmask) << {wa, 3'b000};
    end
endmodule

// File: rtl/udma_regfile.sv
module udma_regfile
    import udma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 24,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CHW-1:0]           wr_ch,
    input  logic [1:0]               wr_sel,
    input  logic [AW-1:0]            wr_data,
    input  logic                     upd,
    input  logic [CHW-1:0]           upd_ch,
    output logic [NCH-1:0][AW-1:0]   src_o,
    output logic [NCH-1:0][AW-1:0]   dst_o,
    output logic [NCH-1:0][CW-1:0]   cnt_o,
    output logic [NCH-1:0][1:0]      size_o,
    output logic [NCH-1:0][1:0]      mode_o,
    output logic [NCH-1:0]           en_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [AW-1:0] stp;
        assign stp = AW'(unit_bytes(size_o[i]));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_o[i]  <= '0;
                dst_o[i]  <= '0;
                cnt_o[i]  <= '0;
                size_o[i] <= '0;
                mode_o[i] <= '0;
                en_o[i]   <= 1'b0;
            end else if (wr_en && wr_ch == CHW'(i)) begin
                case (wr_sel)
                    2'd0: src_o[i] <= wr_data;
                    2'd1: dst_o[i] <= wr_data;
                    2'd2: cnt_o[i] <= wr_data[CW-1:0];
                    default: begin
                        en_o[i]   <= wr_data[0];
                        size_o[i] <= wr_data[2:1];
                        mode_o[i] <= wr_data[4:3];
                    end
                endcase
            end else if (upd && upd_ch == CHW'(i)) begin
                case (mode_o[i])
                    2'd0:    dst_o[i] <= dst_o[i] + stp;
                    2'd1:    dst_o[i] <= dst_o[i] - stp;
                    2'd2:    src_o[i] <= src_o[i] + stp;
                    default: ;
                endcase
                cnt_o[i] <= cnt_o[i] - CW'(1);
                if (cnt_o[i] == CW'(1)) en_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/udma_ctrl.sv
module udma_ctrl
    import udma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 24,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RAW = CHW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    irq_in,
    output logic [NCH-1:0]    done_irq,
    output logic              stall_req,
    input  logic              stall_ack,
    input  logic              reg_we,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    udma_state_e state_q, state_d;

    logic [NCH-1:0]          irq_q, pend_q, trig, elig, ch_en, cnt_nz, take;
    logic [NCH-1:0][AW-1:0]  src_a, dst_a;
    logic [NCH-1:0][CW-1:0]  cnt_a;
    logic [NCH-1:0][1:0]     size_a, mode_a;
    logic                    gnt_vld, upd;
    logic [CHW-1:0]          gnt_idx, cur_q, rd_ch;
    logic [1:0]              rd_sel;
    logic [DATA_W-1:0]       hold_q, rd_val, lane_wdata;
    logic [LANES-1:0]        rd_be, wr_be;

    assign rd_ch  = reg_addr[RAW-1:2];
    assign rd_sel = reg_addr[1:0];
    assign trig   = irq_in & ~irq_q;

    always_comb begin
        for (int i = 0; i < NCH; i++) cnt_nz[i] = |cnt_a[i];
    end
    assign elig = pend_q & ch_en & cnt_nz;
    assign take = (state_q == S_IDLE && gnt_vld) ? (NCH'(1) << gnt_idx) : '0;

    udma_prio #(.N(NCH)) u_prio (
        .req(elig), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    udma_regfile #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_we), .wr_ch(rd_ch), .wr_sel(rd_sel), .wr_data(reg_wdata),
        .upd(upd), .upd_ch(cur_q),
        .src_o(src_a), .dst_o(dst_a), .cnt_o(cnt_a),
        .size_o(size_a), .mode_o(mode_a), .en_o(ch_en)
    );

    udma_lanes u_lanes (
        .size(size_a[cur_q]),
        .rd_off(src_a[cur_q][1:0]), .wr_off(dst_a[cur_q][1:0]),
        .rdata(mem_rdata), .hold(hold_q),
        .rd_val(rd_val), .rd_be(rd_be), .wr_be(wr_be), .wr_data(lane_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: grant, acknowledge, fetch done, store done, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (gnt_vld)   state_d = S_HOLD;
            S_HOLD:  if (stall_ack) state_d = S_READ;
            S_READ:                 state_d = S_WRITE;
            S_WRITE:                state_d = S_STEP;
            S_STEP:                 state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // trigger capture, channel selection and data holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= '0;
            pend_q <= '0;
            cur_q  <= '0;
            hold_q <= '0;
        end else begin
            irq_q  <= irq_in;
            pend_q <= (pend_q & ~take) | trig;
            if (state_q == S_IDLE && gnt_vld) cur_q <= gnt_idx;
            if (state_q == S_READ) hold_q <= rd_val;
        end
    end

    // outputs
    always_comb begin
        stall_req = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        upd       = 1'b0;
        done_irq  = '0;
        unique case (state_q)
            S_IDLE: ;
            S_HOLD: stall_req = 1'b1;
            S_READ: begin
                stall_req = 1'b1;
                mem_req   = 1'b1;
                mem_addr  = src_a[cur_q];
                mem_be    = rd_be;
            end
            S_WRITE: begin
                stall_req = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_a[cur_q];
                mem_be    = wr_be;
                mem_wdata = lane_wdata;
            end
            S_STEP: begin
                upd = 1'b1;
                if (cnt_a[cur_q] == CW'(1)) done_irq[cur_q] = 1'b1;
            end
            default: ;
        endcase
    end

    // register readback
    always_comb begin
        case (rd_sel)
            2'd0:    reg_rdata = src_a[rd_ch];
            2'd1:    reg_rdata = dst_a[rd_ch];
            2'd2:    reg_rdata = AW'(cnt_a[rd_ch]);
            default: reg_rdata = AW'({mode_a[rd_ch], size_a[rd_ch], ch_en[rd_ch]});
        endcase
    end
endmodule

// File: rtl/udma_ctrl_chk.sv
module udma_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stall_req,
    input logic           stall_ack,
    input logic           mem_req,
    input logic           mem_we,
    input logic [3:0]     mem_be,
    input logic [NCH-1:0] done_irq,
    input logic [NCH-1:0] ch_en
);
    // R7
    mem_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (stall_req && stall_ack));

    // R7
    ack_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && stall_ack && !mem_req) |=> (mem_req && !mem_we));

    // R7
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !stall_req);

    // R9
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mem_req && mem_we));

    // R4
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_irq));

    // R4
    done_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_irq) |=> ((ch_en & $past(done_irq)) == '0));

    // R2
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                     $countones(mem_be) == 4));
endmodule

bind udma_ctrl udma_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .stall_ack(stall_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .done_irq(done_irq), .ch_en(ch_en)
);

// File: tb/tb_udma_ctrl.sv
`timescale 1ns/1ps
module tb_udma_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_in = '0;
    logic [3:0]  done_irq;
    logic        stall_req, stall_ack;
    logic        ack_hold = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;

    logic [31:0] mem [0:255];
    logic [7:0]  expb [0:1023];
    logic [23:0] wlog [0:63];
    int          wlog_n = 0;
    int          done_cnt [0:3];
    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;
    assign stall_ack = stall_req & ~ack_hold;
    assign mem_rdata = mem[mem_addr[9:2]];

    udma_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .done_irq(done_irq),
        .stall_req(stall_req), .stall_ack(stall_ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    initial for (int c = 0; c < 4; c++) done_cnt[c] = 0;

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            if (wlog_n < 64) wlog[wlog_n] <= mem_addr;
            wlog_n <= wlog_n + 1;
        end
        for (int c = 0; c < 4; c++)
            if (done_irq[c]) done_cnt[c] <= done_cnt[c] + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 24'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [23:0] v);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        irq_in = m;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mem_init();
        for (int w = 0; w < 256; w++)
            for (int b = 0; b < 4; b++) begin
                mem[w][8*b +: 8] = pat(w * 4 + b);
                expb[w * 4 + b]  = pat(w * 4 + b);
            end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        logic [23:0] v;
        mem_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk(v == 0, "R8 reg after reset", v, 0);
        end
        chk(!stall_req && !mem_req && done_irq == 0, "R8 outputs after reset",
            {stall_req, mem_req, done_irq}, 0);

        // R1 readback
        wr(4'h9, 24'hABCDEF); rd(4'h9, v);
        chk(v == 24'hABCDEF, "R1 dst readback ch2", v, 24'hABCDEF);
        wr(4'h7, 24'hFFFFFF); rd(4'h7, v);
        chk(v == 24'h00001F, "R1 ctrl readback ch1", v, 24'h1F);
        wr(4'h7, 0);

        // R2 R3 R4 sweep over size and mode
        for (int sz = 0; sz < 3; sz++) begin
            for (int md = 0; md < 4; md++) begin
                int ch, u, s0, d0, sf, df, dbase, bad_w;
                ch = (sz + md) % 4;
                u  = 1 << sz;
                s0 = 24'h000040 + u;
                d0 = (md == 1) ? 24'h000240 : 24'h000200;
                mem_init();
                for (int k = 0; k < 3; k++) begin
                    int s, d;
                    s = s0 + ((md == 2) ? k * u : 0);
                    d = d0 + ((md == 0) ? k * u : (md == 1) ? -k * u : 0);
                    for (int j = 0; j < u; j++) expb[d + j] = pat(s + j);
                end
                sf = s0 + ((md == 2) ? 3 * u : 0);
                df = d0 + ((md == 0) ? 3 * u : (md == 1) ? -3 * u : 0);
                dbase = done_cnt[ch];
                wr(ch * 4 + 0, s0);
                wr(ch * 4 + 1, d0);
                wr(ch * 4 + 2, 3);
                wr(ch * 4 + 3, (md << 3) | (sz << 1) | 1);
                for (int k = 0; k < 3; k++) begin
                    pulse(4'(1 << ch));
                    idle(12);
                end
                bad_w = -1;
                for (int w = 120; w < 160; w++)
                    if (mem[w] != {expb[w*4+3], expb[w*4+2], expb[w*4+1], expb[w*4]} && bad_w < 0)
                        bad_w = w;
                chk(bad_w < 0, "R2 R3 destination bytes",
                    (bad_w < 0) ? 0 : mem[bad_w],
                    (bad_w < 0) ? 0 : {expb[bad_w*4+3], expb[bad_w*4+2], expb[bad_w*4+1], expb[bad_w*4]});
                rd(ch * 4 + 0, v); chk(v == 24'(sf), "R3 final source", v, sf);
                rd(ch * 4 + 1, v); chk(v == 24'(df), "R3 final destination", v, df);
                rd(ch * 4 + 2, v); chk(v == 0, "R4 count exhausted", v, 0);
                rd(ch * 4 + 3, v);
                chk(v == 24'((md << 3) | (sz << 1)), "R4 enable cleared", v, (md << 3) | (sz << 1));
                chk(done_cnt[ch] - dbase == 1, "R4 one done pulse", done_cnt[ch] - dbase, 1);
            end
        end

        // R6 priority: all four triggered together
        mem_init();
        for (int c = 0; c < 4; c++) begin
            wr(c * 4 + 0, 24'h000080 + c * 4);
            wr(c * 4 + 1, 24'h000300 + c * 4);
            wr(c * 4 + 2, 1);
            wr(c * 4 + 3, 5);
        end
        wlog_n = 0;
        pulse(4'hF);
        idle(40);
        chk(wlog_n == 4, "R6 service count", wlog_n, 4);
        for (int k = 0; k < 4; k++)
            chk(wlog[k] == 24'(24'h000300 + k * 4), "R6 service order", wlog[k], 24'h300 + k * 4);

        // R5 disabled channel latches a single trigger
        wr(4'h4, 24'h000040); wr(4'h5, 24'h000200); wr(4'h6, 5); wr(4'h7, 4);
        wlog_n = 0;
        pulse(4'h2); pulse(4'h2); pulse(4'h2);
        idle(12);
        chk(wlog_n == 0, "R5 no transfer while disabled", wlog_n, 0);
        rd(4'h6, v); chk(v == 5, "R5 count untouched while disabled", v, 5);
        wr(4'h7, 5);
        idle(30);
        rd(4'h6, v); chk(v == 4, "R5 exactly one latched service", v, 4);

        // R5 trigger during a busy service is kept once
        wr(4'h0, 24'h000040); wr(4'h1, 24'h000200); wr(4'h2, 5); wr(4'h3, 1);
        pulse(4'h1); pulse(4'h1); pulse(4'h1);
        idle(30);
        rd(4'h2, v); chk(v == 3, "R5 busy trigger kept once", v, 3);

        // R7 no memory cycle before acknowledge
        wr(4'h8, 24'h000040); wr(4'h9, 24'h000200); wr(4'hA, 2); wr(4'hB, 1);
        ack_hold = 1'b1;
        wlog_n = 0;
        pulse(4'h4);
        idle(20);
        chk(stall_req == 1'b1, "R7 stall held while waiting", stall_req, 1);
        chk(wlog_n == 0 && !mem_req, "R7 no memory cycle before ack", wlog_n, 0);
        rd(4'hA, v); chk(v == 2, "R7 count unchanged before ack", v, 2);
        ack_hold = 1'b0;
        idle(12);
        rd(4'hA, v); chk(v == 1, "R7 service after ack", v, 1);
        chk(stall_req == 1'b0, "R7 stall released", stall_req, 0);
        chk(wlog_n == 1, "R9 one write per service", wlog_n, 1);

        summary();
    end
endmodule